// File: doc/BRIEF.md
# CAN Bit Stuffer and Error Frame Generator

This block sits between a CAN frame serializer and the bus transceiver. On the transmit side it watches each bit the serializer hands over. While the stuffing window is open and five equal bits have gone out, it emits one bit of the opposite level. During that bit time it holds the serializer off through a look-ahead ready signal. On request it drops the frame in progress and sends an error frame instead: six dominant bits, eight recessive delimiter bits and a three-bit recessive gap. No stuffing is applied to that sequence.

On the receive side it samples the incoming bus bit on the same bit strobe. It removes the bit that follows any run of five equal bits inside the window, and it passes the remaining bits on with a one-cycle valid pulse. When that sixth bit repeats the run's level instead of breaking it, the block raises a one-cycle stuff-error pulse and produces no valid pulse for that bit. Bit timing and CRC are handled elsewhere. All bit-level actions happen on clock edges where `bit_stb` is high.

Top module: `can_stuff_unit`

## Requirements
- R1: After reset, `tx_dout` is 1 (recessive), `tx_rdy` is 1, and `rx_vld` and `rx_stuff_err` are 0.
- R2: While `tx_win` is high, after five consecutive equal bits on `tx_dout`, the next bit sent is their complement, and the pending serializer bit is sent one bit time later.
- R3: An inserted stuff bit counts as the first bit of a new run. For example, the bytes 0xFF then 0x00, sent MSB first, receive stuff bits inside both bytes.
- R4: `tx_rdy` is a look-ahead signal: when it is high, `tx_din` is consumed at the next strobe. It is low for exactly one bit period before each stuff bit, so the number of strobes with `tx_rdy` low equals the number of stuff bits.
- R5: While `tx_win` is low, `tx_din` passes through unchanged with no stuffing and `tx_rdy` stays high. The run count restarts when the window opens, so bits sent before the window do not count.
- R6: A one-cycle pulse on `err_req` pulls `tx_rdy` low from the following cycle. At the next strobe it starts the error frame: 6 bits of 0, then 8 bits of 1, then 3 bits of 1. The frame ignores `tx_din` and `tx_win`, is never stuffed, and `tx_rdy` returns high after its last bit.
- R7: While `rx_win` is high, the received bit that follows five equal bits is discarded and gives no `rx_vld` pulse. The other bits come out in order on `rx_dout`.
- R8: While `rx_win` is high, if the bit after five equal bits has the same level, `rx_stuff_err` pulses for one cycle and `rx_vld` stays low for that bit.
- R9: While `rx_win` is low, every received bit is passed on with `rx_vld`, and no stuff error is raised even for long runs.
- R10: `rx_vld`, `rx_dout` and `rx_stuff_err` are registered. They are valid for the single cycle after the strobe edge and return to 0 (`rx_vld`, `rx_stuff_err`) on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking each bit boundary |
| tx_win | input | 1 | Transmit stuffing window (start of frame through CRC) |
| tx_din | input | 1 | Serializer bit, taken at a strobe when `tx_rdy` is high |
| err_req | input | 1 | Request to send an error frame |
| tx_rdy | output | 1 | Look-ahead ready to the serializer |
| tx_dout | output | 1 | Bit driven toward the bus |
| rx_win | input | 1 | Receive destuffing window |
| rx_din | input | 1 | Bit sampled from the bus |
| rx_dout | output | 1 | Destuffed received bit |
| rx_vld | output | 1 | One-cycle pulse qualifying `rx_dout` |
| rx_stuff_err | output | 1 | One-cycle stuff-violation pulse |

## Verification
- **Transmit bit:** `tx_dout` takes its new value on the strobe edge, so the bench samples it at the falling edge right after that strobe.
- **Ready signal:** `tx_rdy` is a combinational look-ahead. The bench reads it one time step after setting `tx_win`, before raising the strobe. This is also how it decides whether the serializer bit was consumed.
- **Error request:** it is latched one cycle after `err_req`, so `tx_rdy` is checked at the next falling edge. The 17 frame bits are then checked on the next 17 strobes.
- **Receive outputs:** they appear in the single cycle after the strobe edge and are checked there. One further cycle later the bench confirms that the pulses have cleared.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;
  localparam int DEF_RUN_MAX = 5;
  localparam int DEF_ERR_DOM = 6;
  localparam int DEF_ERR_REC = 8;
  localparam int DEF_GAP     = 3;

  // Level of error-sequence bit number pos: dominant for the first dom bits.
  function automatic logic errseq_level(input int pos, input int dom);
    return (pos < dom) ? 1'b0 : 1'b1;
  endfunction

  // Run length after appending bit b behind prev (run==0 means fresh window).
  function automatic int run_after(input int run, input logic prev, input logic b);
    if (run == 0 || b != prev) return 1;
    return run + 1;
  endfunction
endpackage

// File: rtl/can_stuff_tx.sv
module can_stuff_tx
  import can_stuff_pkg::*;
#(
  parameter int RUN_MAX = DEF_RUN_MAX,
  parameter int ERR_DOM = DEF_ERR_DOM,
  parameter int ERR_REC = DEF_ERR_REC,
  parameter int GAP     = DEF_GAP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic tx_win,
  input  logic tx_din,
  input  logic err_req,
  output logic tx_rdy,
  output logic tx_dout
);
  localparam int SEQ_LEN = ERR_DOM + ERR_REC + GAP;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int POS_W   = $clog2(SEQ_LEN + 1);

  logic [RUN_W-1:0] run_q;
  logic [POS_W-1:0] pos_q;
  logic             dout_q, pend_q, act_q;

  // Named internal events
  logic err_hold, err_start, stuff_evt;
  assign err_hold  = pend_q || act_q;
  assign err_start = bit_stb && pend_q && !act_q;
  assign stuff_evt = tx_win && (run_q == RUN_W'(RUN_MAX)) && !err_hold;

  assign tx_rdy  = !err_hold && !stuff_evt;
  assign tx_dout = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      pos_q  <= '0;
      dout_q <= 1'b1;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (err_start)            pend_q <= 1'b0;
      else if (err_req && !act_q) pend_q <= 1'b1;

      if (bit_stb) begin
        if (act_q) begin
          dout_q <= errseq_level(int'(pos_q), ERR_DOM);
          run_q  <= '0;
          if (pos_q == POS_W'(SEQ_LEN - 1)) act_q <= 1'b0;
          else                              pos_q <= pos_q + 1'b1;
        end else if (pend_q) begin
          dout_q <= errseq_level(0, ERR_DOM);
          act_q  <= 1'b1;
          pos_q  <= POS_W'(1);
          run_q  <= '0;
        end else if (!tx_win) begin
          dout_q <= tx_din;
          run_q  <= '0;
        end else if (stuff_evt) begin
          dout_q <= ~dout_q;
          run_q  <= RUN_W'(1);
        end else begin
          dout_q <= tx_din;
          run_q  <= RUN_W'(run_after(int'(run_q), dout_q, tx_din));
        end
      end else if (!tx_win) begin
        run_q <= '0;
      end
    end
  end

  AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && stuff_evt) |=> (tx_dout != $past(tx_dout))); // R2
  AST_RDY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && stuff_evt && !err_req) |=> tx_rdy); // R4
  AST_ERR_STARTS_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    err_start |=> !tx_dout); // R6
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RUN_MAX)); // R2
endmodule

// File: rtl/can_stuff_rx.sv
module can_stuff_rx
  import can_stuff_pkg::*;
#(
  parameter int RUN_MAX = DEF_RUN_MAX
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_win,
  input  logic rx_din,
  output logic rx_dout,
  output logic rx_vld,
  output logic rx_stuff_err
);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_q;
  logic             last_q, vld_q, dout_q, err_q;

  // Named internal events
  logic stuff_slot, stuff_bad;
  assign stuff_slot = rx_win && (run_q == RUN_W'(RUN_MAX));
  assign stuff_bad  = stuff_slot && (rx_din == last_q);

  assign rx_dout      = dout_q;
  assign rx_vld       = vld_q;
  assign rx_stuff_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
      vld_q  <= 1'b0;
      dout_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      if (bit_stb) begin
        if (!rx_win) begin
          vld_q  <= 1'b1;
          dout_q <= rx_din;
          run_q  <= '0;
          last_q <= rx_din;
        end else if (stuff_slot) begin
          if (stuff_bad) begin
            err_q <= 1'b1;
            run_q <= '0;
          end else begin
            run_q  <= RUN_W'(1);
            last_q <= rx_din;
          end
        end else begin
          vld_q  <= 1'b1;
          dout_q <= rx_din;
          run_q  <= RUN_W'(run_after(int'(run_q), last_q, rx_din));
          last_q <= rx_din;
        end
      end else if (!rx_win) begin
        run_q <= '0;
      end
    end
  end

  AST_RX_DROPS_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && stuff_slot) |=> !rx_vld); // R7
  AST_RX_ERR_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_vld); // R8
  AST_RX_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |=> !rx_stuff_err); // R8
  AST_RX_NO_ERR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !rx_win) |=> (rx_vld && !rx_stuff_err)); // R9
endmodule

// File: rtl/can_stuff_unit.sv
module can_stuff_unit
  import can_stuff_pkg::*;
#(
  parameter int RUN_MAX = DEF_RUN_MAX,
  parameter int ERR_DOM = DEF_ERR_DOM,
  parameter int ERR_REC = DEF_ERR_REC,
  parameter int GAP     = DEF_GAP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic tx_win,
  input  logic tx_din,
  input  logic err_req,
  output logic tx_rdy,
  output logic tx_dout,
  input  logic rx_win,
  input  logic rx_din,
  output logic rx_dout,
  output logic rx_vld,
  output logic rx_stuff_err
);
  can_stuff_tx #(
    .RUN_MAX(RUN_MAX), .ERR_DOM(ERR_DOM), .ERR_REC(ERR_REC), .GAP(GAP)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_win(tx_win),
    .tx_din(tx_din), .err_req(err_req), .tx_rdy(tx_rdy), .tx_dout(tx_dout)
  );

  can_stuff_rx #(
    .RUN_MAX(RUN_MAX)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_win(rx_win),
    .rx_din(rx_din), .rx_dout(rx_dout), .rx_vld(rx_vld), .rx_stuff_err(rx_stuff_err)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (tx_dout && !rx_vld && !rx_stuff_err)); // R1
endmodule

// File: tb/test_can_stuff_unit.sv
`timescale 1ns/1ps
module test_can_stuff_unit;
  typedef logic bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, tx_win = 1'b0, tx_din = 1'b1, err_req = 1'b0;
  logic rx_win = 1'b0, rx_din = 1'b1;
  logic tx_rdy, tx_dout, rx_dout, rx_vld, rx_stuff_err;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  can_stuff_unit i_can_stuff_unit (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_win(tx_win), .tx_din(tx_din),
    .err_req(err_req), .tx_rdy(tx_rdy), .tx_dout(tx_dout), .rx_win(rx_win),
    .rx_din(rx_din), .rx_dout(rx_dout), .rx_vld(rx_vld), .rx_stuff_err(rx_stuff_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference: true when the last five emitted bits share one level.
  function automatic bit tail_equal(bq_t e);
    int n = e.size();
    if (n < 5) return 1'b0;
    for (int k = n - 5; k < n; k++) if (e[k] != e[n-1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bq_t stuff_model(bq_t d);
    bq_t e = {};
    foreach (d[i]) begin
      if (tail_equal(e)) e.push_back(~e[e.size()-1]);
      e.push_back(d[i]);
    end
    if (tail_equal(e)) e.push_back(~e[e.size()-1]);
    return e;
  endfunction

  function automatic bq_t to_bits(input int val, input int nb);
    bq_t b = {};
    for (int k = nb - 1; k >= 0; k--) b.push_back(val[k]);
    return b;
  endfunction

  task automatic tx_bit(input logic din, input logic win, output logic rdy, output logic o);
    @(negedge clk);
    tx_din = din; tx_win = win;
    #1 rdy = tx_rdy;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    o = tx_dout;
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_bit(input logic din, input logic win, output logic v, output logic d, output logic er);
    @(negedge clk);
    rx_din = din; rx_win = win; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    v = rx_vld; d = rx_dout; er = rx_stuff_err;
    @(negedge clk);
    chk(!rx_vld && !rx_stuff_err, "R10", "rx pulses clear one cycle later", int'(rx_vld | rx_stuff_err), 0);
    @(negedge clk);
  endtask

  task automatic send_tx(input bq_t bits, input string req);
    bq_t q = bits;
    bq_t exp = stuff_model(bits);
    bq_t got = {};
    int lows = 0;
    for (int g = 0; g < 400; g++) begin
      logic win, r, o;
      win = (q.size() > 0) || !tx_rdy;
      if (!win) break;
      tx_bit((q.size() > 0) ? q[0] : 1'b1, 1'b1, r, o);
      got.push_back(o);
      if (r) void'(q.pop_front());
      else lows++;
    end
    tx_win = 1'b0;
    @(negedge clk);
    chk(got.size() == exp.size(), req, "stuffed length", got.size(), exp.size());
    foreach (exp[i]) if (i < got.size())
      chk(got[i] == exp[i], req, $sformatf("tx bit %0d", i), int'(got[i]), int'(exp[i]));
    chk(lows == exp.size() - bits.size(), "R4", "strobes with tx_rdy low", lows, exp.size() - bits.size());
  endtask

  task automatic send_rx(input bq_t bits);
    bq_t line = stuff_model(bits);
    bq_t got = {};
    int errs = 0;
    foreach (line[i]) begin
      logic v, d, er;
      rx_bit(line[i], 1'b1, v, d, er);
      if (v) got.push_back(d);
      if (er) errs++;
    end
    rx_win = 1'b0;
    chk(got.size() == bits.size(), "R7", "destuffed length", got.size(), bits.size());
    foreach (bits[i]) if (i < got.size())
      chk(got[i] == bits[i], "R7", $sformatf("rx bit %0d", i), int'(got[i]), int'(bits[i]));
    chk(errs == 0, "R7", "no stuff error on legal stream", errs, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic r, o, v, d, er;
    repeat (3) @(negedge clk);
    chk(tx_dout == 1'b1, "R1", "tx_dout in reset", int'(tx_dout), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_dout == 1'b1 && tx_rdy == 1'b1, "R1", "tx idle after reset", int'({tx_dout, tx_rdy}), 3);
    chk(!rx_vld && !rx_stuff_err, "R1", "rx idle after reset", int'({rx_vld, rx_stuff_err}), 0);

    // R2 R3 R4: 0xFF then 0x00
    send_tx(to_bits(16'hFF00, 16), "R3");
    // R2: identifier-like pattern plus data
    send_tx({to_bits(11'h0AF, 11), to_bits(8'h0F, 8), to_bits(8'hC4, 8), to_bits(16'hFFFF, 16)}, "R2");
    send_tx(to_bits(24'h000000, 24), "R2");

    // R5: outside the window no stuffing, ready stays high
    for (int k = 0; k < 8; k++) begin
      tx_bit(1'b0, 1'b0, r, o);
      chk(r == 1'b1, "R5", "rdy outside window", int'(r), 1);
      chk(o == 1'b0, "R5", "pass-through outside window", int'(o), 0);
    end
    for (int k = 0; k < 2; k++) begin
      tx_bit(1'b0, 1'b1, r, o);
      chk(r == 1'b1 && o == 1'b0, "R5", "run restarts at window open", int'({r, o}), 2);
    end
    tx_win = 1'b0;
    @(negedge clk);

    // R6: error frame aborts a frame in progress
    for (int k = 0; k < 4; k++) tx_bit(1'b1, 1'b1, r, o);
    @(negedge clk);
    err_req = 1'b1;
    @(negedge clk);
    err_req = 1'b0;
    chk(tx_rdy == 1'b0, "R6", "rdy drops after request", int'(tx_rdy), 0);
    for (int k = 0; k < 17; k++) begin
      tx_bit(1'b0, 1'b1, r, o);
      chk(r == 1'b0, "R6", $sformatf("rdy low before error bit %0d", k), int'(r), 0);
      chk(o == ((k < 6) ? 1'b0 : 1'b1), "R6", $sformatf("error frame bit %0d", k), int'(o), (k < 6) ? 0 : 1);
    end
    #1;
    chk(tx_rdy == 1'b1, "R6", "rdy back after gap", int'(tx_rdy), 1);
    tx_win = 1'b0;
    @(negedge clk);

    // R7: legal destuffing
    send_rx(to_bits(16'hFF00, 16));
    send_rx({to_bits(11'h0AF, 11), to_bits(16'h0000, 16), 1'b1});

    // R8: six equal bits in window, both polarities
    for (int p = 0; p < 2; p++) begin
      logic lvl = p[0];
      for (int k = 0; k < 5; k++) begin
        rx_bit(lvl, 1'b1, v, d, er);
        chk(v && !er && d == lvl, "R8", "run bit accepted", int'({v, er}), 2);
      end
      rx_bit(lvl, 1'b1, v, d, er);
      chk(er == 1'b1, "R8", "stuff error raised", int'(er), 1);
      chk(v == 1'b0, "R8", "no valid on violation", int'(v), 0);
      rx_win = 1'b0;
      @(negedge clk);
    end

    // R9: long run outside window
    for (int k = 0; k < 8; k++) begin
      rx_bit(1'b0, 1'b0, v, d, er);
      chk(v && !er && d == 1'b0, "R9", "bit passed outside window", int'({v, er, d}), 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule